// File: doc/BRIEF.md
# Bundle Execution-Group Dependency Checker

This block sits behind instruction fetch in a wide-issue front end. It accepts one 128-bit, three-slot instruction bundle per cycle, together with register fields already sliced out of each slot. It splits the slot stream into execution groups. A group closes after any slot whose stop bit is set in the bundle template, and after any slot that holds a taken branch. When neither occurs, a group carries on into the next bundle.

Inside a group, no instruction may read or write a register that an earlier instruction of the same group wrote. The block tracks the registers written so far in the open group. It flags the first slot that breaks this rule and reports why. It also flags slot-placement rule violations and a reserved template class.

Results for each accepted bundle appear one cycle later:
- a group number for each slot,
- a per-slot group-end mask,
- a violation flag with the offending slot and a reason code.

Slot `k` occupies bundle bits `[45+41k : 5+41k]`, and bits `[4:0]` are the template.

Top module: `bgc_group_check`

## Requirements
- R1: Template bits [2:0] (bundle bits 2:0) mark a stop after slot 0, 1 and 2 respectively. A live slot with its stop bit set raises its bit of `grp_end_o`. The next live slot opens a new group whose written-register record is empty.
- R2: `taken_i[k]` counts only when slot k's kind is branch (kind 2). A counted taken branch ends the group after slot k. The later slots of that bundle are not live (`slot_live_o` low) and take no part in checks or in the written-register record.
- R3: Group numbers start at 0 after reset. All live slots of one group carry the same number. The number rises by one, modulo 2^GID_W, after every group end.
- R4: A live slot with an enabled, nonzero source register (either source) that an earlier slot of the same group wrote raises a violation with code 1.
- R5: A live slot with an enabled, nonzero destination that an earlier slot of the same group wrote raises a violation with code 2.
- R6: Register 0 is never recorded as written and never causes a violation.
- R7: A register written in one bundle stays recorded in the following bundles until a group end occurs.
- R8: The slot kinds are 0 integer, 1 memory, 2 branch and 3 other. Slot 0 holding kind 3, slot 2 holding kind 1, or template bits [4:3] equal to 3 raise a violation with code 3. The template case is reported on slot 0.
- R9: When several slots violate, the lowest slot is reported. Within one slot, code 1 beats code 2, which beats code 3.
- R10: `ready_o` is low in reset and high from the first clock edge after it. The results of a bundle accepted at an edge are held for exactly the following cycle with `out_valid_o` high. `bundle_o` echoes the bundle.
- R11: During reset `out_valid_o`, `viol_o` and `slot_live_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Bundle present |
| ready_o | output | 1 | Bundle can be taken |
| bundle_i | input | 128 | Bundle: three slots and template |
| src_a_i | input | 3*REG_W | First source register per slot |
| src_a_en_i | input | 3 | First source in use per slot |
| src_b_i | input | 3*REG_W | Second source register per slot |
| src_b_en_i | input | 3 | Second source in use per slot |
| dst_i | input | 3*REG_W | Destination register per slot |
| dst_en_i | input | 3 | Destination in use per slot |
| kind_i | input | 6 | Two-bit instruction kind per slot |
| taken_i | input | 3 | Branch in slot is taken |
| out_valid_o | output | 1 | Results present |
| bundle_o | output | 128 | Echoed bundle |
| slot_live_o | output | 3 | Slot survives taken-branch truncation |
| grp_end_o | output | 3 | Group closes after this slot |
| grp_id_o | output | 3*GID_W | Group number per slot |
| viol_o | output | 1 | Rule broken in this bundle |
| viol_slot_o | output | 2 | Lowest offending slot |
| viol_code_o | output | 2 | 1 read hazard, 2 write hazard, 3 slot rule |

## Verification
The stimulus targets several corner cases:
- A read hazard whose producer sits in the previous bundle. A design that clears its record at every bundle edge would miss it.
- A stop between slots 1 and 2. A design that ignores the stop would report a false read hazard.
- A taken branch followed by a slot that would otherwise clash, and a taken flag on a non-branch slot. The first catches a design that leaves dead slots live. The second catches one that ends groups on any taken flag.
- Register 0 used as source and destination, which must stay silent.
- Slots with two rules broken at once, which expose a wrong priority.
- A run of all-stop bundles that wraps the group counter.

// File: rtl/bgc_pkg.sv
`timescale 1ns/1ps
package bgc_pkg;
  localparam int NSLOT    = 3;
  localparam int BUNDLE_W = 128;
  localparam int TMPL_W   = 5;
  localparam int SLOT_IW  = $clog2(NSLOT);

  typedef enum logic [1:0] {
    K_INT = 2'd0,
    K_MEM = 2'd1,
    K_BR  = 2'd2,
    K_OTH = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    VC_NONE = 2'd0,
    VC_RAW  = 2'd1,
    VC_WAW  = 2'd2,
    VC_SLOT = 2'd3
  } vcode_e;

  localparam logic [1:0] CLS_RSVD = 2'b11;
endpackage

// File: rtl/bgc_slot_dep.sv
`timescale 1ns/1ps
module bgc_slot_dep #(
  parameter  int NREG  = 128,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic             live_i,
  input  logic             end_i,
  input  logic [NREG-1:0]  mask_i,
  input  logic [REG_W-1:0] src_a_i,
  input  logic             src_a_en_i,
  input  logic [REG_W-1:0] src_b_i,
  input  logic             src_b_en_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             dst_en_i,
  output logic             raw_o,
  output logic             waw_o,
  output logic [NREG-1:0]  mask_o
);
  logic a_hit, b_hit, d_wr;

  assign a_hit = src_a_en_i && (src_a_i != '0) && mask_i[src_a_i];
  assign b_hit = src_b_en_i && (src_b_i != '0) && mask_i[src_b_i];
  assign d_wr  = live_i && dst_en_i && (dst_i != '0);

  assign raw_o = live_i && (a_hit || b_hit);
  assign waw_o = d_wr && mask_i[dst_i];

  always_comb begin
    mask_o = mask_i;
    if (d_wr) mask_o[dst_i] = 1'b1;
    if (live_i && end_i) mask_o = '0;
  end
endmodule

// File: rtl/bgc_viol_pick.sv
`timescale 1ns/1ps
module bgc_viol_pick
  import bgc_pkg::*;
#(
  parameter  int N  = 3,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  raw_i,
  input  logic [N-1:0]  waw_i,
  input  logic [N-1:0]  bad_i,
  output logic          hit_o,
  output logic [SW-1:0] slot_o,
  output vcode_e        code_o
);
  // descending scan so the lowest offending slot wins
  always_comb begin
    hit_o  = 1'b0;
    slot_o = '0;
    code_o = VC_NONE;
    for (int k = N - 1; k >= 0; k--) begin
      if (raw_i[k] || waw_i[k] || bad_i[k]) begin
        hit_o  = 1'b1;
        slot_o = SW'(k);
        code_o = raw_i[k] ? VC_RAW : (waw_i[k] ? VC_WAW : VC_SLOT);
      end
    end
  end
endmodule

// File: rtl/bgc_group_check.sv
`timescale 1ns/1ps
module bgc_group_check
  import bgc_pkg::*;
#(
  parameter  int NREG  = 128,
  parameter  int GID_W = 4,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  output logic                    ready_o,
  input  logic [BUNDLE_W-1:0]     bundle_i,
  input  logic [NSLOT*REG_W-1:0]  src_a_i,
  input  logic [NSLOT-1:0]        src_a_en_i,
  input  logic [NSLOT*REG_W-1:0]  src_b_i,
  input  logic [NSLOT-1:0]        src_b_en_i,
  input  logic [NSLOT*REG_W-1:0]  dst_i,
  input  logic [NSLOT-1:0]        dst_en_i,
  input  logic [NSLOT*2-1:0]      kind_i,
  input  logic [NSLOT-1:0]        taken_i,
  output logic                    out_valid_o,
  output logic [BUNDLE_W-1:0]     bundle_o,
  output logic [NSLOT-1:0]        slot_live_o,
  output logic [NSLOT-1:0]        grp_end_o,
  output logic [NSLOT*GID_W-1:0]  grp_id_o,
  output logic                    viol_o,
  output logic [SLOT_IW-1:0]      viol_slot_o,
  output logic [1:0]              viol_code_o
);
  logic                        rdy_q, accept;
  logic [TMPL_W-1:0]           tmpl;
  logic [NSLOT-1:0]            stop, live, tk, ends, raw, waw, bad;
  logic [1:0]                  cls;
  logic [NREG-1:0]             mask_q;
  logic [NREG-1:0]             mask_c [NSLOT+1];
  logic [GID_W-1:0]            gid_q;
  logic [GID_W-1:0]            gid_c  [NSLOT+1];
  logic [NSLOT*GID_W-1:0]      gid_flat;
  logic                        hit;
  logic [SLOT_IW-1:0]          hit_slot;
  vcode_e                      hit_code;

  logic                        ov_q, viol_q;
  logic [NSLOT-1:0]            live_q, end_q;
  logic [NSLOT*GID_W-1:0]      gido_q;
  logic [SLOT_IW-1:0]          vslot_q;
  vcode_e                      vcode_q;
  logic [BUNDLE_W-1:0]         bnd_q;

  assign ready_o = rdy_q;
  assign accept  = valid_i && rdy_q;
  assign tmpl    = bundle_i[TMPL_W-1:0];
  assign stop    = tmpl[NSLOT-1:0];
  assign cls     = tmpl[TMPL_W-1:NSLOT];

  assign mask_c[0] = mask_q;
  assign gid_c[0]  = gid_q;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    kind_e kd;
    assign kd    = kind_e'(kind_i[2*k +: 2]);
    assign tk[k] = taken_i[k] && (kd == K_BR);

    if (k == 0) begin : g_head
      assign live[k] = 1'b1;
    end else begin : g_tail
      assign live[k] = live[k-1] && !tk[k-1];
    end

    assign ends[k] = live[k] && (stop[k] || tk[k]);

    // slot placement rules
    if (k == 0) begin : g_r0
      assign bad[k] = live[k] && ((kd == K_OTH) || (cls == CLS_RSVD));
    end else if (k == NSLOT - 1) begin : g_rl
      assign bad[k] = live[k] && (kd == K_MEM);
    end else begin : g_rm
      assign bad[k] = 1'b0;
    end

    bgc_slot_dep #(.NREG(NREG)) u_dep (
      .live_i     (live[k]),
      .end_i      (ends[k]),
      .mask_i     (mask_c[k]),
      .src_a_i    (src_a_i[k*REG_W +: REG_W]),
      .src_a_en_i (src_a_en_i[k]),
      .src_b_i    (src_b_i[k*REG_W +: REG_W]),
      .src_b_en_i (src_b_en_i[k]),
      .dst_i      (dst_i[k*REG_W +: REG_W]),
      .dst_en_i   (dst_en_i[k]),
      .raw_o      (raw[k]),
      .waw_o      (waw[k]),
      .mask_o     (mask_c[k+1])
    );

    assign gid_c[k+1]                 = gid_c[k] + GID_W'(ends[k]);
    assign gid_flat[k*GID_W +: GID_W] = gid_c[k];
  end

  bgc_viol_pick #(.N(NSLOT)) u_pick (
    .raw_i  (raw),
    .waw_i  (waw),
    .bad_i  (bad),
    .hit_o  (hit),
    .slot_o (hit_slot),
    .code_o (hit_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      mask_q  <= '0;
      gid_q   <= '0;
      ov_q    <= 1'b0;
      live_q  <= '0;
      end_q   <= '0;
      gido_q  <= '0;
      viol_q  <= 1'b0;
      vslot_q <= '0;
      vcode_q <= VC_NONE;
      bnd_q   <= '0;
    end else begin
      rdy_q <= 1'b1;
      ov_q  <= accept;
      if (accept) begin
        mask_q  <= mask_c[NSLOT];
        gid_q   <= gid_c[NSLOT];
        live_q  <= live;
        end_q   <= ends;
        gido_q  <= gid_flat;
        viol_q  <= hit;
        vslot_q <= hit_slot;
        vcode_q <= hit_code;
        bnd_q   <= bundle_i;
      end else begin
        live_q  <= '0;
        end_q   <= '0;
        viol_q  <= 1'b0;
        vcode_q <= VC_NONE;
      end
    end
  end

  assign out_valid_o = ov_q;
  assign bundle_o    = bnd_q;
  assign slot_live_o = live_q;
  assign grp_end_o   = end_q;
  assign grp_id_o    = gido_q;
  assign viol_o      = viol_q;
  assign viol_slot_o = vslot_q;
  assign viol_code_o = vcode_q;
endmodule

// File: rtl/bgc_checker.sv
`timescale 1ns/1ps
module bgc_checker
  import bgc_pkg::*;
#(
  parameter  int NREG  = 128,
  parameter  int GID_W = 4,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    ready_o,
  input  logic [BUNDLE_W-1:0]     bundle_i,
  input  logic [NSLOT*REG_W-1:0]  src_a_i,
  input  logic [NSLOT-1:0]        src_a_en_i,
  input  logic [NSLOT*REG_W-1:0]  src_b_i,
  input  logic [NSLOT-1:0]        src_b_en_i,
  input  logic [NSLOT*REG_W-1:0]  dst_i,
  input  logic [NSLOT-1:0]        dst_en_i,
  input  logic [NSLOT*2-1:0]      kind_i,
  input  logic [NSLOT-1:0]        taken_i,
  input  logic                    out_valid_o,
  input  logic [BUNDLE_W-1:0]     bundle_o,
  input  logic [NSLOT-1:0]        slot_live_o,
  input  logic [NSLOT-1:0]        grp_end_o,
  input  logic [NSLOT*GID_W-1:0]  grp_id_o,
  input  logic                    viol_o,
  input  logic [SLOT_IW-1:0]      viol_slot_o,
  input  logic [1:0]              viol_code_o
);
  logic [GID_W-1:0] gid0, gid1;
  assign gid0 = grp_id_o[0 +: GID_W];
  assign gid1 = grp_id_o[GID_W +: GID_W];

  AST_END_ON_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_end_o & ~slot_live_o) == '0); // R1
  AST_LIVE_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_live_o[2] |-> slot_live_o[1] && slot_live_o[0]); // R2
  AST_HEAD_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> slot_live_o[0]); // R2
  AST_GID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && slot_live_o[1] && !grp_end_o[0] |-> gid1 == gid0); // R3
  AST_GID_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && slot_live_o[1] && grp_end_o[0] |-> gid1 == gid0 + 1'b1); // R3
  AST_VIOL_SANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> viol_code_o != 2'd0 && viol_slot_o < 2'(NSLOT) && slot_live_o[viol_slot_o]); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> !viol_o && grp_end_o == '0 && slot_live_o == '0); // R10
  AST_OUT_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(valid_i && ready_o)); // R10
endmodule

bind bgc_group_check bgc_checker #(.NREG(NREG), .GID_W(GID_W)) u_chk (.*);

// File: tb/tb_bgc_group_check.sv
`timescale 1ns/1ps
module tb_bgc_group_check;
  localparam int RW = 7;
  localparam int GW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         valid_i = 1'b0;
  logic         ready_o;
  logic [127:0] bundle_i = '0;
  logic [20:0]  src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic [2:0]   src_a_en_i = '0, src_b_en_i = '0, dst_en_i = '0, taken_i = '0;
  logic [5:0]   kind_i = '0;
  logic         out_valid_o, viol_o;
  logic [127:0] bundle_o;
  logic [2:0]   slot_live_o, grp_end_o;
  logic [11:0]  grp_id_o;
  logic [1:0]   viol_slot_o, viol_code_o;

  bgc_group_check #(.NREG(128), .GID_W(GW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .ready_o(ready_o),
    .bundle_i(bundle_i), .src_a_i(src_a_i), .src_a_en_i(src_a_en_i),
    .src_b_i(src_b_i), .src_b_en_i(src_b_en_i), .dst_i(dst_i), .dst_en_i(dst_en_i),
    .kind_i(kind_i), .taken_i(taken_i), .out_valid_o(out_valid_o), .bundle_o(bundle_o),
    .slot_live_o(slot_live_o), .grp_end_o(grp_end_o), .grp_id_o(grp_id_o),
    .viol_o(viol_o), .viol_slot_o(viol_slot_o), .viol_code_o(viol_code_o)
  );

  typedef struct {
    string        tag;
    logic [127:0] bnd;
    logic [2:0]   live, gend;
    logic [11:0]  gid;
    logic         v;
    logic [1:0]   vs, vc;
  } exp_t;

  exp_t         sbq[$];
  exp_t         em;
  logic [127:0] m_mask = '0;
  int           m_gid = 0;
  int           n_chk = 0, n_fail = 0, seq = 0;
  bit           done = 0;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // reference model from the requirements, then drive one bundle
  task automatic send(string tag, logic [20:0] sa, logic [20:0] sb, logic [20:0] dd,
                      logic [2:0] ae, logic [2:0] be, logic [2:0] de,
                      logic [5:0] kd, logic [2:0] tk, logic [4:0] tm);
    exp_t e;
    bit alive = 1;
    seq++;
    e.tag = tag; e.live = 0; e.gend = 0; e.gid = 0; e.v = 0; e.vs = 0; e.vc = 0;
    e.bnd = {32'(seq) * 32'h9e37_79b9, 32'(seq) ^ 32'h5a5a_a5a5, 32'(seq), 27'(seq * 7), tm};
    for (int k = 0; k < 3; k++) begin
      int a, b, d;
      bit raw, waw, bad, tke;
      if (!alive) continue;
      e.live[k] = 1'b1;
      a = int'(sa[k*RW +: RW]); b = int'(sb[k*RW +: RW]); d = int'(dd[k*RW +: RW]);
      raw = (ae[k] && a != 0 && m_mask[a]) || (be[k] && b != 0 && m_mask[b]);
      waw = de[k] && d != 0 && m_mask[d];
      bad = (k == 0 && (kd[1:0] == 2'd3 || tm[4:3] == 2'd3)) || (k == 2 && kd[5:4] == 2'd1);
      if (!e.v && (raw || waw || bad)) begin
        e.v = 1; e.vs = 2'(k); e.vc = raw ? 2'd1 : (waw ? 2'd2 : 2'd3);
      end
      e.gid[k*GW +: GW] = GW'(m_gid);
      if (de[k] && d != 0) m_mask[d] = 1'b1;
      tke = tk[k] && kd[2*k +: 2] == 2'd2;
      if (tm[k] || tke) begin
        e.gend[k] = 1'b1; m_mask = '0; m_gid = (m_gid + 1) % (1 << GW);
      end
      if (tke) alive = 0;
    end
    sbq.push_back(e);
    while (!ready_o) @(negedge clk);
    bundle_i = e.bnd; src_a_i = sa; src_b_i = sb; dst_i = dd;
    src_a_en_i = ae; src_b_en_i = be; dst_en_i = de; kind_i = kd; taken_i = tk;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid_o) begin
      if (sbq.size() == 0) chk(0, "R10", "unexpected result", 1, 0);
      else begin
        em = sbq.pop_front();
        chk(slot_live_o == em.live, em.tag, "live", slot_live_o, em.live);
        chk(grp_end_o == em.gend, em.tag, "group end", grp_end_o, em.gend);
        for (int k = 0; k < 3; k++)
          if (em.live[k])
            chk(grp_id_o[k*GW +: GW] == em.gid[k*GW +: GW], "R3", "group id",
                grp_id_o[k*GW +: GW], em.gid[k*GW +: GW]);
        chk({viol_o, viol_slot_o, viol_code_o} == {em.v, em.vs, em.vc}, em.tag,
            "violation", {viol_o, viol_slot_o, viol_code_o}, {em.v, em.vs, em.vc});
        chk(bundle_o == em.bnd, "R10", "bundle echo", bundle_o, em.bnd);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid_o && !viol_o && slot_live_o == 0, "R11", "reset outputs",
        {out_valid_o, viol_o, slot_live_o}, 0);
    chk(!ready_o, "R10", "ready in reset", ready_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready_o, "R10", "ready after reset", ready_o, 1);

    // R7: producer in earlier bundle, R4 read hazard in the next
    send("R7", 0, 0, {7'd3, 7'd2, 7'd1}, 0, 0, 3'b111, 0, 0, 5'b00000);
    send("R7", {7'd0, 7'd2, 7'd1}, 0, {7'd2, 7'd0, 7'd0}, 3'b011, 0, 3'b100, 0, 0, 5'b00001);
    // R1: stop after slot 1
    send("R1", {7'd10, 7'd0, 7'd0}, 0, {7'd0, 7'd11, 7'd10}, 3'b100, 0, 3'b011, 0, 0, 5'b00010);
    // R5
    send("R5", 0, 0, {7'd0, 7'd5, 7'd5}, 0, 0, 3'b011, 0, 0, 5'b00100);
    // R6
    send("R6", {7'd0, 7'd0, 7'd0}, {7'd0, 7'd0, 7'd0}, {7'd0, 7'd0, 7'd0},
         3'b010, 3'b010, 3'b101, 0, 0, 5'b00100);
    // R2: taken branch in slot 1 kills slot 2
    send("R2", {7'd9, 7'd0, 7'd0}, 0, {7'd9, 7'd0, 7'd9}, 3'b100, 0, 3'b101,
         {2'd0, 2'd2, 2'd0}, 3'b010, 5'b00000);
    send("R2", {7'd0, 7'd0, 7'd9}, 0, 0, 3'b001, 0, 0, 0, 0, 5'b00000);
    // R2: taken flag on non-branch is ignored
    send("R2", 0, 0, {7'd12, 7'd0, 7'd12}, 0, 0, 3'b101, 0, 3'b001, 5'b00100);
    // R8
    send("R8", 0, 0, 0, 0, 0, 0, {2'd0, 2'd0, 2'd3}, 0, 5'b00100);
    send("R8", 0, 0, 0, 0, 0, 0, {2'd1, 2'd0, 2'd0}, 0, 5'b00100);
    send("R8", 0, 0, 0, 0, 0, 0, 0, 0, 5'b11100);
    send("R8", 0, 0, 0, 0, 0, 0, {2'd0, 2'd1, 2'd1}, 0, 5'b00100);
    // R9
    send("R9", {7'd0, 7'd7, 7'd0}, 0, {7'd7, 7'd0, 7'd7}, 3'b010, 0, 3'b101, 0, 0, 5'b00100);
    send("R9", {7'd0, 7'd8, 7'd0}, 0, {7'd0, 7'd8, 7'd8}, 3'b010, 0, 3'b011, 0, 0, 5'b00100);
    send("R9", 0, 0, {7'd4, 7'd0, 7'd4}, 0, 0, 3'b101, {2'd1, 2'd0, 2'd0}, 0, 5'b00100);
    // R4 through second source
    send("R4", 0, {7'd0, 7'd6, 7'd0}, {7'd0, 7'd0, 7'd6}, 0, 3'b010, 3'b001, 0, 0, 5'b00100);
    // R3: wrap of group number
    for (int i = 0; i < 6; i++) send("R3", 0, 0, 0, 0, 0, 0, 0, 0, 5'b00111);

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R10", "pending results", sbq.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule